// File: doc/BRIEF.md
# Pipelined Serial Booth Fractional Multiplier

This block multiplies two 20-bit two's-complement fractions and keeps running without stopping. A value of 1 LSB stands for 2^-19, so the range is -1.0 up to 1 - 2^-19. Both operands arrive bit-serially, least significant bit first, one bit per clock. The product leaves on a single serial line in the same order. A one-cycle frame-sync pulse marks the start of each 20-bit word. On that edge three things happen at once: the two operand words just received are handed to the multiply engine, the engine's finished product is moved into the output shifter, and the first bit of the next operand word is taken in.

The engine uses radix-2 Booth recoding. Each clock it adds the multiplicand, subtracts it, or does neither, and then shifts arithmetically right. The first of its 20 steps is merged into the loading edge, so a product is ready before the next sync. The unit therefore holds three words in flight (incoming operands, the product being formed, outgoing product) and yields one result per word time. The fractional result keeps the upper half of the double-length product, rounded toward minus infinity. The single overflow case, -1.0 times -1.0, saturates.

The data flows at a fixed rate set by the frame sync. There is no valid/ready back-pressure: the bit stream cannot be stalled, and the source has to keep syncs at least 20 clocks apart.

Top module: `booth_frac_mul`

## Requirements
- R1: Each operand is taken least significant bit first, one bit per rising edge. The word loaded at a sync edge is the 20 bits sampled on the 20 edges before it. The bit sampled on the sync edge itself is bit 0 of the following word.
- R2: For operands a and b read as fractions (value/2^19), the result r is the 20-bit two's-complement code with r = floor(a*b*2^19). Small negative products therefore become -1 LSB (0xFFFFF).
- R3: The code pair 0x80000 times 0x80000 (-1.0 times -1.0) gives 0x7FFFF.
- R4: The product of the operands loaded at sync edge S goes out at the next sync edge S', least significant bit first. Bit k is on prod_sdo in the cycle after edge S'+k.
- R5: With a sync every 20 clocks, every word time delivers a new product with no idle frames in between.
- R6: If more than 20 clocks pass between syncs, prod_sdo is 0 once all 20 product bits have been sent, and stays 0 until the next sync edge.
- R7: During and after reset prod_sdo is 0. The word sent out on the first sync after reset is all zeros.
- R8: The engine finishes 19 edges after the loading sync edge. Its result then stays unchanged until the next sync, however long the frame lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | One-cycle word start; loads operands and moves the product out |
| mcand_sdi | input | 1 | Multiplicand serial data, LSB first |
| mplier_sdi | input | 1 | Multiplier serial data, LSB first |
| prod_sdo | output | 1 | Product serial data, LSB first |

## Verification
The saturation case is the hardest to reach from the ports. It needs exactly the pattern 0x80000 on both serial inputs in the same frame, so the stimulus sends it as a directed frame between random ones and follows its product two frames later. Stretched frames are the other hard case. Here junk bits are sent ahead of the real operand, and the gap after the 20th product bit shows whether only the last 20 bits are used and whether the held result and the idle-zero output behave. A behavioural queue model predicts every output bit and compares it with prod_sdo on every clock.

// File: rtl/smul_pkg.sv
package smul_pkg;

  typedef enum logic [1:0] {
    BOOTH_HOLD = 2'd0,
    BOOTH_ADD  = 2'd1,
    BOOTH_SUB  = 2'd2
  } booth_op_e;

  localparam int unsigned NUM_OPERANDS = 2;
  localparam int unsigned OPND_MCAND   = 0;
  localparam int unsigned OPND_MPLIER  = 1;

  // Radix-2 recoding on the current multiplier bit and the one shifted out before it
  function automatic booth_op_e booth_decode(input logic cur, input logic prev);
    case ({cur, prev})
      2'b01:   return BOOTH_ADD;
      2'b10:   return BOOTH_SUB;
      default: return BOOTH_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/smul_shift_in.sv
module smul_shift_in #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sdi,
  output logic [W-1:0] word
);

  // LSB-first stream: new bits enter at the top, so after W edges bit 0 sits at word[0]
  always_ff @(posedge clk) begin
    if (!rst_n) word <= '0;
    else        word <= {sdi, word[W-1:1]};
  end

endmodule

// File: rtl/smul_shift_out.sv
module smul_shift_out #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word_i,
  output logic         sdo
);

  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)    sr <= '0;
    else if (load) sr <= word_i;
    else           sr <= {1'b0, sr[W-1:1]};
  end

  assign sdo = sr[0];

endmodule

// File: rtl/smul_booth_core.sv
module smul_booth_core
  import smul_pkg::*;
#(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] mplier_i,
  output logic [W-1:0] result_o,
  output logic         done_o
);

  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam int unsigned PW    = 2 * W;
  localparam logic [CNT_W-1:0] LAST_STEP  = CNT_W'(W);
  localparam logic [CNT_W-1:0] FIRST_STEP = CNT_W'(1);
  localparam logic [W-1:0] FRAC_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] FRAC_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]     mc;
  logic [W:0]       acc;
  logic [W-1:0]     mq;
  logic             qp;
  logic [CNT_W-1:0] cnt;
  logic             active;

  // Step operands: on a load edge the first step runs on the fresh words
  logic [W-1:0] mc_s, mq_s;
  logic [W:0]   acc_s, mc_x, sum;
  logic         qp_s;
  booth_op_e    op;
  logic [W:0]   acc_n;
  logic [W-1:0] mq_n;

  always_comb begin
    mc_s  = load ? mcand_i  : mc;
    mq_s  = load ? mplier_i : mq;
    acc_s = load ? '0       : acc;
    qp_s  = load ? 1'b0     : qp;
    mc_x  = {mc_s[W-1], mc_s};
    op    = booth_decode(mq_s[0], qp_s);
    case (op)
      BOOTH_ADD: sum = acc_s + mc_x;
      BOOTH_SUB: sum = acc_s - mc_x;
      default:   sum = acc_s;
    endcase
    acc_n = {sum[W], sum[W:1]};
    mq_n  = {sum[0], mq_s[W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mc     <= '0;
      acc    <= '0;
      mq     <= '0;
      qp     <= 1'b0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      mc     <= mcand_i;
      acc    <= acc_n;
      mq     <= mq_n;
      qp     <= mq_s[0];
      cnt    <= FIRST_STEP;
      active <= 1'b1;
    end else if (active && cnt != LAST_STEP) begin
      acc    <= acc_n;
      mq     <= mq_n;
      qp     <= mq_s[0];
      cnt    <= cnt + FIRST_STEP;
    end
  end

  // Double-length product; keep sign plus the top W-1 fraction bits (floor)
  logic [PW-1:0] prod;
  logic          ovf;

  always_comb begin
    prod     = {acc[W-1:0], mq};
    ovf      = prod[PW-1] ^ prod[PW-2];
    result_o = ovf ? (prod[PW-1] ? FRAC_MIN : FRAC_MAX) : prod[PW-2:W-1];
  end

  assign done_o = active && (cnt == LAST_STEP);

endmodule

// File: rtl/booth_frac_mul.sv
module booth_frac_mul
  import smul_pkg::*;
#(
  parameter int unsigned W = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_sync,
  input  logic mcand_sdi,
  input  logic mplier_sdi,
  output logic prod_sdo
);

  logic [NUM_OPERANDS-1:0] sdi_vec;
  logic [W-1:0]            op_word [NUM_OPERANDS];
  logic [W-1:0]            mcand_word, mplier_word;
  logic [W-1:0]            eng_result;
  logic                    eng_done;

  assign sdi_vec[OPND_MCAND]  = mcand_sdi;
  assign sdi_vec[OPND_MPLIER] = mplier_sdi;

  for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_opnd
    smul_shift_in #(.W(W)) u_in (
      .clk  (clk),
      .rst_n(rst_n),
      .sdi  (sdi_vec[g]),
      .word (op_word[g])
    );
  end

  assign mcand_word  = op_word[OPND_MCAND];
  assign mplier_word = op_word[OPND_MPLIER];

  smul_booth_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (frame_sync),
    .mcand_i (mcand_word),
    .mplier_i(mplier_word),
    .result_o(eng_result),
    .done_o  (eng_done)
  );

  smul_shift_out #(.W(W)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (frame_sync),
    .word_i(eng_result),
    .sdo   (prod_sdo)
  );

endmodule

// File: rtl/booth_frac_mul_chk.sv
module booth_frac_mul_chk #(
  parameter int unsigned W = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         frame_sync,
  input logic         prod_sdo,
  input logic [W-1:0] mcand_word,
  input logic [W-1:0] mplier_word,
  input logic [W-1:0] eng_result,
  input logic         eng_done
);

  localparam int unsigned GW = $clog2(W + 1);
  localparam logic [GW-1:0] GAP_SAT  = GW'(W);
  localparam logic [GW-1:0] GAP_DONE = GW'(W - 1);
  localparam logic [W-1:0] FRAC_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] FRAC_MIN = {1'b1, {(W-1){1'b0}}};

  logic [GW-1:0] gap;
  logic          seen;
  logic [W-1:0]  cap_a, cap_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap   <= GAP_SAT;
      seen  <= 1'b0;
      cap_a <= '0;
      cap_b <= '0;
    end else if (frame_sync) begin
      gap   <= '0;
      seen  <= 1'b1;
      cap_a <= mcand_word;
      cap_b <= mplier_word;
    end else if (gap != GAP_SAT) begin
      gap   <= gap + GW'(1);
    end
  end

  p_done_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done == (seen && gap >= GAP_DONE));

  p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !frame_sync) |=> $stable(eng_result));

  p_first_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (prod_sdo == $past(eng_result[0])));

  p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gap == GAP_SAT) |-> !prod_sdo);

  p_saturate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && cap_a == FRAC_MIN && cap_b == FRAC_MIN) |-> (eng_result == FRAC_MAX));

  p_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && cap_a != '0 && cap_b != '0 && !(cap_a == FRAC_MIN && cap_b == FRAC_MIN))
      |-> (eng_result[W-1] == (cap_a[W-1] ^ cap_b[W-1])));

endmodule

bind booth_frac_mul booth_frac_mul_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_sync (frame_sync),
  .prod_sdo   (prod_sdo),
  .mcand_word (mcand_word),
  .mplier_word(mplier_word),
  .eng_result (eng_result),
  .eng_done   (eng_done)
);

// File: tb/booth_frac_mul_bench.sv
module booth_frac_mul_bench;

  localparam int W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_sync = 1'b0;
  logic mcand_sdi = 1'b0;
  logic mplier_sdi = 1'b0;
  logic prod_sdo;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  booth_frac_mul #(.W(W)) u_booth_frac_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_sync(frame_sync),
    .mcand_sdi (mcand_sdi),
    .mplier_sdi(mplier_sdi),
    .prod_sdo  (prod_sdo)
  );

  // Behavioural reference state
  int          a_q[$];
  int          b_q[$];
  int          exp_q[$];
  logic [19:0] eng_res;
  string       eng_tag;
  string       out_tag;

  function automatic logic [19:0] ref_mul(input logic [19:0] a, input logic [19:0] b);
    longint sa = a[19] ? longint'(a) - 64'sd1048576 : longint'(a);
    longint sb = b[19] ? longint'(b) - 64'sd1048576 : longint'(b);
    longint p  = sa * sb;
    longint r  = p >>> 19;
    if (r > 64'sd524287) r = 64'sd524287;
    return r[19:0];
  endfunction

  function automatic logic [19:0] q_word(input int q[$]);
    logic [19:0] w = '0;
    for (int i = 0; i < 20; i++) w[i] = q[i][0];
    return w;
  endfunction

  task automatic check(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: prod_sdo actual %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic s, input logic a, input logic b, input string tag);
    logic  exp_bit;
    string t;
    frame_sync = s;
    mcand_sdi  = a;
    mplier_sdi = b;
    @(posedge clk);
    if (s) begin
      exp_q.delete();
      for (int i = 0; i < 20; i++) exp_q.push_back(int'(eng_res[i]));
      out_tag = eng_tag;
      eng_res = ref_mul(q_word(a_q), q_word(b_q));
      eng_tag = tag;
    end else if (exp_q.size() > 0) begin
      void'(exp_q.pop_front());
    end
    a_q.push_back(int'(a));
    b_q.push_back(int'(b));
    void'(a_q.pop_front());
    void'(b_q.pop_front());
    @(negedge clk);
    exp_bit = (exp_q.size() > 0) ? exp_q[0][0] : 1'b0;
    t = (exp_q.size() > 0) ? out_tag : "R6 idle";
    check(prod_sdo, exp_bit, t);
  endtask

  // Junk bits fill the start of a stretched frame; the operand is always the last 20 bits
  task automatic run_frame(input logic [19:0] a, input logic [19:0] b, input int len,
                           input string tag);
    for (int c = 0; c < len; c++) begin
      int   k;
      logic ab, bb;
      k = c - (len - 20);
      if (k >= 0) begin
        ab = a[k];
        bb = b[k];
      end else begin
        ab = 1'($urandom);
        bb = 1'($urandom);
      end
      step(c == 0, ab, bb, tag);
    end
  endtask

  initial begin
    for (int i = 0; i < 20; i++) begin
      a_q.push_back(0);
      b_q.push_back(0);
    end
    eng_res = '0;
    eng_tag = "R7 first word after reset";
    out_tag = "R7";
    repeat (3) @(negedge clk);
    check(prod_sdo, 1'b0, "R7 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(prod_sdo, 1'b0, "R7 after reset");

    run_frame(20'h40000, 20'h40000, 20, "R2 half by half");
    run_frame(20'h80000, 20'h80000, 20, "R3 minus one squared");
    run_frame(20'h00001, 20'hFFFFF, 20, "R2 floor of tiny negative");
    run_frame(20'h80000, 20'h7FFFF, 20, "R2 min by max");
    run_frame(20'h7FFFF, 20'h7FFFF, 20, "R2 max squared");
    run_frame(20'h00000, 20'h5A5A5, 20, "R2 zero operand");
    run_frame(20'hC0000, 20'h20000, 20, "R2 negative by positive");
    run_frame(20'h80000, 20'h80000, 20, "R3 repeat");
    for (int n = 0; n < 30; n++)
      run_frame(20'($urandom), 20'($urandom), 20, "R5 back-to-back R4 order");
    for (int n = 0; n < 8; n++)
      run_frame(20'($urandom), 20'($urandom), 21 + int'($urandom % 9),
                "R1 last 20 bits R8 held");
    run_frame(20'h80000, 20'h80000, 27, "R3 stretched R1");
    run_frame(20'h00003, 20'hFFFFD, 20, "R2 floor");
    run_frame(20'h0, 20'h0, 25, "R4 drain");
    run_frame(20'h0, 20'h0, 25, "R4 drain");

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule